// File: doc/BRIEF.md
# Interrupt Status Coalescing Controller

This block gathers hardware events into a host interrupt. Each event pulse sets a sticky bit in a 32-bit main status register. A second 32-bit status register records events from the DMA engines, and those events also fold into summary bits of the main status. The host clears bits by writing ones to them, and chooses which main bits may interrupt through an enable register.

The interrupt line goes through a coalescing timer. After the first enabled event, the line stays low for a programmable number of 32-microsecond units. A high-priority receive event skips this wait. A periodic timer sets a receive-periodic status bit at a programmable interval. A microsecond tick input drives both timers through a shared divider.

The host reaches four 32-bit words through a word-indexed register port with byte strobes. Word 0 is configuration: byte 0 is the coalescing count and byte 1 is the periodic count. Word 1 is the main status, word 2 is the enable register, and word 3 is the DMA status.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: Writing to word 1 or word 3 clears every strobed status bit written as 1 and leaves every bit written as 0 unchanged. Status bits never clear in any other way.
- R2: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R3: A DMA event on bit 16 or 17 sets main bit 31. A DMA event on bit 0 or 1 sets main bit 27. A DMA event on bit 31 sets main bit 29. Each DMA event also sets its own bit in word 3.
- R4: After reset the enable register holds 0xAA00008B, and the configuration and both status registers read 0.
- R5: With a coalescing count of 0, the interrupt rises on the second clock edge after an enabled event is presented. Events on bits that are not enabled never raise it.
- R6: With a coalescing count N > 0, the interrupt rises no sooner than (N-1)*32 and no later than N*32 microsecond ticks after the status becomes pending.
- R7: A DMA event on bit 30 (high-priority receive) raises the interrupt on the next clock edge whatever the coalescing count, provided main bit 31 is enabled. It also sets main bit 31.
- R8: A nonzero periodic count P sets main bit 28 once every P*32 microsecond ticks. A count of 0 stops it.
- R9: The interrupt falls one clock edge after no enabled status bit remains set, whether the bits were acknowledged or masked.
- R10: A read returns the addressed word on the edge after the read strobe. Configuration bits 31:16 read 0, and byte strobes confine a write to the bytes they select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ev_main | input | 32 | Event pulses for the main status |
| ev_dma | input | 32 | Event pulses for the DMA status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word select |
| reg_strb | input | 4 | Byte strobes for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Host interrupt |

## Verification
An event and the host's clearing write can hit the same status bit in the same cycle. The bench drives both on one edge and then reads the word back, expecting the bit still set. A second collision happens when a high-priority receive event arrives while the coalescing timer is running with a long count. The bench starts that timer and expects the interrupt one edge after the event, long before the window would close.

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl #(
  parameter int          UNIT_US  = 32,
  parameter logic [31:0] MASK_RST = 32'hAA00008B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic [31:0] ev_main,
  input  logic [31:0] ev_dma,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [3:0]  reg_strb,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int PW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;

  logic [PW-1:0] pre_q;
  logic [7:0]  coal_q, per_q, per_cnt, tmr_q;
  logic [31:0] st_main, st_dma, mask_q;
  logic        tmr_on, irq_q;

  wire unit_tick = us_tick && (pre_q == PW'(UNIT_US - 1));
  wire [31:0] wmask = {{8{reg_strb[3]}}, {8{reg_strb[2]}}, {8{reg_strb[1]}}, {8{reg_strb[0]}}};
  wire sel_cfg  = reg_wr && reg_addr == 2'd0;
  wire sel_main = reg_wr && reg_addr == 2'd1;
  wire sel_en   = reg_wr && reg_addr == 2'd2;
  wire sel_dma  = reg_wr && reg_addr == 2'd3;

  wire per_fire = unit_tick && per_q != 8'd0 && (8'(per_cnt + 8'd1) == per_q);
  wire hp       = ev_dma[30] && mask_q[31];

  logic [31:0] fold;
  always_comb begin
    fold     = 32'd0;
    fold[31] = |ev_dma[17:16] | ev_dma[30];
    fold[29] = ev_dma[31];
    fold[28] = per_fire;
    fold[27] = |ev_dma[1:0];
  end

  wire [31:0] main_set = ev_main | fold;
  wire [31:0] main_clr = sel_main ? (reg_wdata & wmask) : 32'd0;
  wire [31:0] dma_clr  = sel_dma  ? (reg_wdata & wmask) : 32'd0;
  wire        pend     = |(st_main & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else if (us_tick) pre_q <= unit_tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coal_q <= 8'd0;
      per_q  <= 8'd0;
      mask_q <= MASK_RST;
    end else begin
      if (sel_cfg && reg_strb[0]) coal_q <= reg_wdata[7:0];
      if (sel_cfg && reg_strb[1]) per_q  <= reg_wdata[15:8];
      if (sel_en) mask_q <= (mask_q & ~wmask) | (reg_wdata & wmask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_main <= 32'd0;
      st_dma  <= 32'd0;
    end else begin
      st_main <= (st_main & ~main_clr) | main_set;
      st_dma  <= (st_dma & ~dma_clr) | ev_dma;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || per_q == 8'd0 || (sel_cfg && reg_strb[1])) per_cnt <= 8'd0;
    else if (unit_tick) per_cnt <= per_fire ? 8'd0 : per_cnt + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      tmr_on <= 1'b0;
      tmr_q  <= 8'd0;
    end else if (hp) begin
      irq_q  <= 1'b1;
      tmr_on <= 1'b0;
    end else if (irq_q) begin
      if (!pend) irq_q <= 1'b0;
    end else if (tmr_on) begin
      if (!pend) tmr_on <= 1'b0;
      else if (unit_tick && tmr_q <= 8'd1) begin
        irq_q  <= 1'b1;
        tmr_on <= 1'b0;
      end else if (unit_tick) tmr_q <= tmr_q - 8'd1;
    end else if (pend) begin
      if (coal_q == 8'd0) irq_q <= 1'b1;
      else begin
        tmr_on <= 1'b1;
        tmr_q  <= coal_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= 32'd0;
    else if (reg_rd) begin
      case (reg_addr)
        2'd0:    reg_rdata <= {16'd0, per_q, coal_q};
        2'd1:    reg_rdata <= st_main;
        2'd2:    reg_rdata <= mask_q;
        default: reg_rdata <= st_dma;
      endcase
    end
  end

  assign irq = irq_q;

  assert_w1c_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(main_clr & ~main_set)) |=> ((st_main & $past(main_clr & ~main_set)) == 32'd0));
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_main |=> ((~st_main & $past(st_main)) == 32'd0));
  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(main_clr & main_set)) |=> ((st_main & $past(main_clr & main_set)) == $past(main_clr & main_set)));
  assert_reset_state_R4: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == MASK_RST && st_main == 32'd0 && st_dma == 32'd0));
  assert_delay_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(hp) && $past(coal_q) != 8'd0) |-> $past(tmr_on));
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hp |=> irq);
  assert_periodic_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    per_fire |=> st_main[28]);
  assert_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pend && !hp) |=> !irq);
endmodule

// File: tb/test_irq_coalesce_ctrl.sv
module test_irq_coalesce_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0;
  logic [31:0] ev_main = '0, ev_dma = '0, reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0, reg_rd = 1'b0, irq;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_strb = '0;
  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  irq_coalesce_ctrl i_irq_coalesce_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ev_main(ev_main), .ev_dma(ev_dma),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_strb(reg_strb),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(reg_rdata === e, t, reg_rdata, e);
    end
  end

  task automatic rd_exp(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_strb = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_strb = '0;
  endtask

  task automatic pulse_main(input logic [31:0] v);
    @(negedge clk); ev_main = v;
    @(negedge clk); ev_main = '0;
  endtask

  task automatic pulse_dma(input logic [31:0] v);
    @(negedge clk); ev_dma = v;
    @(negedge clk); ev_dma = '0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(irq === 1'b0, "R4 irq low after reset", {31'd0, irq}, 0);
    rd_exp(2, 32'hAA00008B, "R4 enable reset value");
    rd_exp(1, 0, "R4 main status reset");
    rd_exp(3, 0, "R4 dma status reset");
    rd_exp(0, 0, "R10 cfg reset");

    // R5: zero coalescing, irq two edges after the event
    @(negedge clk); ev_main = 32'h1;
    @(negedge clk); ev_main = '0;
    chk(irq === 1'b0, "R5 irq not yet after first edge", {31'd0, irq}, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R5 irq on second edge", {31'd0, irq}, 1);

    // R1: zero writes ignored, one writes clear
    wr(1, 4'hF, 32'h0);
    rd_exp(1, 32'h1, "R1 write of zero keeps bit");
    wr(1, 4'hF, 32'h1);
    @(negedge clk);
    chk(irq === 1'b0, "R9 irq falls after acknowledge", {31'd0, irq}, 0);
    rd_exp(1, 32'h0, "R1 write of one clears bit");

    // R5: non-enabled bit never raises irq
    pulse_main(32'h40);
    repeat (4) @(negedge clk);
    chk(irq === 1'b0, "R5 disabled bit no irq", {31'd0, irq}, 0);
    rd_exp(1, 32'h40, "R5 disabled bit still recorded");
    wr(1, 4'h1, 32'h40);

    // R2: set and clear in the same cycle
    @(negedge clk);
    ev_main = 32'h2; reg_wr = 1'b1; reg_addr = 2'd1; reg_strb = 4'hF; reg_wdata = 32'h2;
    @(negedge clk);
    ev_main = '0; reg_wr = 1'b0; reg_strb = '0;
    rd_exp(1, 32'h2, "R2 set wins over clear");
    wr(1, 4'hF, 32'h2);
    @(negedge clk);

    // R3: DMA folding
    pulse_dma(32'h8002_0002);
    rd_exp(3, 32'h8002_0002, "R3 dma status bits");
    rd_exp(1, 32'hA800_0000, "R3 folded main bits");
    wr(3, 4'hF, 32'hFFFF_FFFF);
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd_exp(3, 0, "R1 dma status cleared");
    @(negedge clk);
    chk(irq === 1'b0, "R9 irq low after dma ack", {31'd0, irq}, 0);

    // R9: masking drops irq; R10 byte strobes
    pulse_main(32'h1);
    @(negedge clk);
    chk(irq === 1'b1, "R9 irq up before mask", {31'd0, irq}, 1);
    wr(2, 4'h1, 32'h0);
    @(negedge clk);
    chk(irq === 1'b0, "R9 irq falls when masked", {31'd0, irq}, 0);
    rd_exp(2, 32'hAA00_0000, "R10 byte strobe limits write");
    wr(2, 4'h1, 32'h8B);
    wr(1, 4'hF, 32'h1);

    // R6: coalescing window of 2 units
    us_tick = 1'b1;
    wr(0, 4'h1, 32'h2);
    pulse_main(32'h2);
    begin
      int cyc = 0;
      while (irq !== 1'b1 && cyc < 300) begin
        @(negedge clk); cyc++;
      end
      chk(cyc >= 32 && cyc <= 66, "R6 coalescing delay in window", cyc, 64);
    end
    wr(1, 4'hF, 32'h2);
    @(negedge clk);

    // R7: bypass during long window
    wr(0, 4'h1, 32'hC8);
    pulse_main(32'h1);
    repeat (5) @(negedge clk);
    chk(irq === 1'b0, "R6 irq held while timer runs", {31'd0, irq}, 0);
    @(negedge clk); ev_dma = 32'h4000_0000;
    @(negedge clk); ev_dma = '0;
    chk(irq === 1'b1, "R7 high priority bypass", {31'd0, irq}, 1);
    rd_exp(1, 32'h8000_0001, "R7 bypass sets main bit 31");
    wr(1, 4'hF, 32'hFFFF_FFFF);
    wr(3, 4'hF, 32'hFFFF_FFFF);

    // R8: periodic
    wr(0, 4'h3, 32'h0000_0100);
    rd_exp(0, 32'h0000_0100, "R10 cfg readback");
    repeat (40) @(negedge clk);
    rd_exp(1, 32'h1000_0000, "R8 periodic sets bit 28");
    wr(0, 4'h2, 32'h0);
    wr(1, 4'hF, 32'hFFFF_FFFF);
    repeat (100) @(negedge clk);
    rd_exp(1, 32'h0, "R8 periodic disabled");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule